// File: doc/BRIEF.md
# Edge-Triggered Interrupt Vector Arbiter

This block sits in front of a small sequencer and turns four active-low trigger pins into interrupt vector numbers. Each pin idles high through a pull-up. Its raw level is synchronized and then filtered by a debounce counter. A new level is accepted only after the pin has held it for the whole debounce interval. Every accepted change is either a falling or a rising edge, and each kind on each pin has its own enable bit and its own vector number.

Requests are latched as pending flags. A fixed priority chain grants one of them per clock and emits a single-cycle strobe with the vector number. Two other sources share the chain. A power-on request is raised once, a fixed delay after reset. A jump request, supplied with a target, has the lowest priority. The enable bits live in two byte-wide registers that are written through a simple strobe-and-data port.

Top module: `trig_irq_arbiter`

## Requirements
- R1: While reset is high, `vld_o` stays low. After reset, every used enable bit reads as 1, whatever was written before.
- R2: The debounce interval is TICKS_PER_US×SHORT_US clocks when `deb_long` is 0 and TICKS_PER_US×LONG_US clocks when it is 1. A pin change that is undone before the interval has elapsed produces no request.
- R3: A debounced change from high to low is a falling edge, and a debounced change from low to high is a rising edge.
- R4: Vector codes use pin index p (0..3, matching `trig_n[p]`). Falling codes are 0, 1, 8 and 9, and rising codes are 4, 5, 12 and 13. Bit 3 of the code is p[1], bit 0 is p[0], and bit 2 is set for a rising edge. The power-on request uses code 32.
- R5: Enable byte 0 (`en_we[0]`) holds pin 0 falling in bit 0, pin 1 falling in bit 1, pin 0 rising in bit 4 and pin 1 rising in bit 5. Enable byte 1 (`en_we[1]`) holds pins 2 and 3 in the same positions. Bits 2, 3, 6 and 7 are ignored. An edge whose enable bit is 0 produces no strobe.
- R6: When several requests are pending, they are granted in this order: power-on, then pin 0 falling, pin 0 rising, pin 1 falling, pin 1 rising, pin 2 falling, pin 2 rising, pin 3 falling, pin 3 rising, then the jump.
- R7: A request stays pending until it is granted. Each grant produces exactly one `vld_o` cycle and clears only the flag it served, so back-to-back pending requests come out on consecutive cycles.
- R8: The power-on request is raised once, POI_US×TICKS_PER_US clocks after reset is released. It comes out as vector 32 one clock later.
- R9: A `jmp_req` pulse latches `jmp_tgt`. That value comes out as the vector one clock after the pulse if nothing else is pending, and otherwise after all other pending requests.
- R10: With nothing else pending, the strobe for a pin edge is high on the (L+3)-th rising clock edge after the pin changes, where L is the selected debounce interval in clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_n | input | 4 | Raw active-low trigger pins, index = pin number |
| deb_long | input | 1 | 1 selects the long debounce interval, 0 the short one |
| en_we | input | 2 | Write strobes for enable bytes 0 and 1 |
| en_wdata | input | 8 | Data written to the selected enable byte(s) |
| jmp_req | input | 1 | One-cycle jump request |
| jmp_tgt | input | VEC_W | Vector number for the jump request |
| vld_o | output | 1 | One-cycle vector strobe |
| vec_o | output | VEC_W | Granted vector number, valid with `vld_o` |

## Verification
A pin edge takes two synchronizer stages, then L counting clocks, then the pending register and the output register. Its strobe is therefore due exactly L+3 edges after the stimulus. A jump is due one edge after its request edge, and the power-on strobe is due one edge after the delay expires. Every check counts edges from the stimulus and requires the strobe on the due edge and on no other edge in a window a few cycles wider. Stimulus for ignored cases (short glitches, masked edges) is checked the same way, by requiring silence across the whole window. When several requests are pending together, the strobes are collected over consecutive cycles and compared in order against a list built from the priority rule.

// File: rtl/trig_irq_pkg.sv
`timescale 1ns/1ps
package trig_irq_pkg;
  localparam int NPINS   = 4;
  localparam int NREQ    = 2 * NPINS + 2;
  localparam int POI_IDX = 0;
  localparam int JMP_IDX = NREQ - 1;
  localparam logic [5:0] POI_CODE = 6'd32;

  // pending index 0 = power-on, 1+2p = pin p falling, 2+2p = pin p rising
  function automatic logic [5:0] req_code(input int idx);
    logic [5:0] c;
    logic [1:0] p;
    c = '0;
    if (idx == POI_IDX) begin
      c = POI_CODE;
    end else begin
      p    = 2'((idx - 1) / 2);
      c[3] = p[1];
      c[0] = p[0];
      c[2] = ((idx - 1) % 2) == 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/trig_debounce.sv
`timescale 1ns/1ps
module trig_debounce #(
  parameter int unsigned LIM_SHORT = 1200,
  parameter int unsigned LIM_LONG  = 150000
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic long_sel,
  output logic fall_o,
  output logic rise_o
);
  localparam int CW = $clog2(LIM_LONG + 1);

  logic [1:0]    sync_q;
  logic          lvl_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_m1;
  logic          differ;
  logic          flip;

  assign lim_m1 = long_sel ? CW'(LIM_LONG - 1) : CW'(LIM_SHORT - 1);
  assign differ = sync_q[1] != lvl_q;
  assign flip   = differ && (cnt_q >= lim_m1);
  assign fall_o = flip && lvl_q;
  assign rise_o = flip && !lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 2'b11;
      lvl_q  <= 1'b1;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], pin_n};
      if (!differ || flip) cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
      if (flip) lvl_q <= sync_q[1];
    end
  end

  AST_LVL_FROM_SYNC: assert property (@(posedge clk) disable iff (rst)
    !$stable(lvl_q) |-> (lvl_q == $past(sync_q[1]))); // R2
  AST_CNT_ONLY_WHEN_DIFFER: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> $past(differ)); // R2
endmodule

// File: rtl/poi_timer.sv
`timescale 1ns/1ps
module poi_timer #(
  parameter int unsigned POI_CYC = 480000
) (
  input  logic clk,
  input  logic rst,
  output logic poi_o
);
  localparam int CW = $clog2(POI_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign poi_o = !done_q && (cnt_q == CW'(POI_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (poi_o) done_q <= 1'b1;
    end
  end

  AST_POI_SINGLE: assert property (@(posedge clk) disable iff (rst)
    poi_o |=> (done_q && !poi_o)); // R8
endmodule

// File: rtl/irq_prio_arb.sv
`timescale 1ns/1ps
module irq_prio_arb
  import trig_irq_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NREQ-1:0]  set_i,
  input  logic [VEC_W-1:0] jmp_tgt_i,
  output logic             vld_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [NREQ-1:0]  pend_q;
  logic [NREQ-1:0]  grant;
  logic [VEC_W-1:0] tgt_q;
  logic [5:0]       code;

  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (pend_q[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    code = '0;
    for (int i = 0; i < NREQ - 1; i++)
      if (grant[i]) code = req_code(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      tgt_q  <= '0;
      vld_o  <= 1'b0;
      vec_o  <= '0;
    end else begin
      pend_q <= (pend_q & ~grant) | set_i;
      if (set_i[JMP_IDX]) tgt_q <= jmp_tgt_i;
      vld_o <= |grant;
      if (|grant) vec_o <= grant[JMP_IDX] ? tgt_q : VEC_W'(code);
    end
  end

  AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    vld_o |-> $past(|pend_q)); // R7
  AST_POI_FIRST: assert property (@(posedge clk) disable iff (rst)
    pend_q[POI_IDX] |=> (vld_o && vec_o == VEC_W'(POI_CODE))); // R6
  AST_JMP_LAST: assert property (@(posedge clk) disable iff (rst)
    (pend_q[JMP_IDX] && (pend_q[JMP_IDX-1:0] != '0)) |=> pend_q[JMP_IDX]); // R6

  for (genvar g = 0; g < NREQ; g++) begin : g_chk
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
      (pend_q[g] && !grant[g]) |=> pend_q[g]); // R7
    AST_CLEAR_OWN: assert property (@(posedge clk) disable iff (rst)
      (grant[g] && !set_i[g]) |=> !pend_q[g]); // R7
  end
endmodule

// File: rtl/trig_irq_arbiter.sv
`timescale 1ns/1ps
module trig_irq_arbiter
  import trig_irq_pkg::*;
#(
  parameter int unsigned TICKS_PER_US = 3,
  parameter int unsigned SHORT_US     = 400,
  parameter int unsigned LONG_US      = 50000,
  parameter int unsigned POI_US       = 160000,
  parameter int          VEC_W        = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       trig_n,
  input  logic             deb_long,
  input  logic [1:0]       en_we,
  input  logic [7:0]       en_wdata,
  input  logic             jmp_req,
  input  logic [VEC_W-1:0] jmp_tgt,
  output logic             vld_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam int unsigned LIM_SHORT = TICKS_PER_US * SHORT_US;
  localparam int unsigned LIM_LONG  = TICKS_PER_US * LONG_US;
  localparam int unsigned POI_CYC   = TICKS_PER_US * POI_US;

  // per byte: {rise pin b, rise pin a, fall pin b, fall pin a}
  logic [1:0][3:0]  en_q;
  logic [NREQ-1:0]  set_w;
  logic             poi_w;
  logic             unused_bits;

  assign unused_bits = ^{en_wdata[7:6], en_wdata[3:2]};

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '1;
    end else begin
      for (int r = 0; r < 2; r++)
        if (en_we[r]) en_q[r] <= {en_wdata[5], en_wdata[4], en_wdata[1], en_wdata[0]};
    end
  end

  poi_timer #(.POI_CYC(POI_CYC)) poi_i (
    .clk(clk), .rst(rst), .poi_o(poi_w)
  );

  assign set_w[POI_IDX] = poi_w;
  assign set_w[JMP_IDX] = jmp_req;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic fall_w, rise_w;
    trig_debounce #(.LIM_SHORT(LIM_SHORT), .LIM_LONG(LIM_LONG)) deb_i (
      .clk(clk), .rst(rst), .pin_n(trig_n[p]), .long_sel(deb_long),
      .fall_o(fall_w), .rise_o(rise_w)
    );
    assign set_w[1 + 2*p] = fall_w && en_q[p/2][p%2];
    assign set_w[2 + 2*p] = rise_w && en_q[p/2][2 + p%2];

    AST_MASKED_EDGE: assert property (@(posedge clk) disable iff (rst)
      (fall_w && !en_q[p/2][p%2]) |=> !arb_i.pend_q[1 + 2*p]); // R5
  end

  irq_prio_arb #(.VEC_W(VEC_W)) arb_i (
    .clk(clk), .rst(rst), .set_i(set_w), .jmp_tgt_i(jmp_tgt),
    .vld_o(vld_o), .vec_o(vec_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !vld_o); // R1
endmodule

// File: tb/trig_irq_arbiter_tb.sv
`timescale 1ns/1ps
module trig_irq_arbiter_tb_top;
  localparam int TPU   = 2;
  localparam int SUS   = 5;
  localparam int LUS   = 20;
  localparam int PUS   = 50;
  localparam int LIM_S = TPU * SUS;
  localparam int LIM_L = TPU * LUS;
  localparam int POI_C = TPU * PUS;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] trig_n = 4'hF;
  logic       deb_long = 1'b0;
  logic [1:0] en_we = 2'b00;
  logic [7:0] en_wdata = 8'h00;
  logic       jmp_req = 1'b0;
  logic [7:0] jmp_tgt = 8'h00;
  logic       vld_o;
  logic [7:0] vec_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] seen [8];
  int seen_n;
  int seen_c0;

  always #2.5 clk = ~clk;

  trig_irq_arbiter #(.TICKS_PER_US(TPU), .SHORT_US(SUS), .LONG_US(LUS),
                     .POI_US(PUS), .VEC_W(8)) dut_i (
    .clk(clk), .rst(rst), .trig_n(trig_n), .deb_long(deb_long),
    .en_we(en_we), .en_wdata(en_wdata), .jmp_req(jmp_req), .jmp_tgt(jmp_tgt),
    .vld_o(vld_o), .vec_o(vec_o)
  );

  function automatic logic [7:0] exp_vec(input int p, input bit rise);
    return 8'((p / 2) * 8 + (p % 2) + (rise ? 4 : 0));
  endfunction

  function automatic bit exp_en(input logic [7:0] lo, input logic [7:0] hi,
                                input int p, input bit rise);
    logic [7:0] b;
    b = (p < 2) ? lo : hi;
    return b[(p % 2) + (rise ? 4 : 0)];
  endfunction

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d, expected %0d", req, act, exp);
    end
  endtask

  // want=1: exactly one strobe, on cycle due, carrying ev; want=0: none
  task automatic expect_strobe(input int due, input int span, input bit want,
                               input logic [7:0] ev, input string req);
    int at;
    int extra;
    logic [7:0] gv;
    at = -1; extra = 0; gv = 8'h00;
    for (int c = 1; c <= span; c++) begin
      cyc();
      if (vld_o) begin
        if (at < 0) begin at = c; gv = vec_o; end
        else extra++;
      end
    end
    n_chk++;
    if (want ? !(at == due && gv == ev && extra == 0) : (at >= 0)) begin
      n_bad++;
      if (want)
        $display("FAIL %s: strobe at cycle %0d vector %0d (+%0d extra), expected cycle %0d vector %0d",
                 req, at, gv, extra, due, ev);
      else
        $display("FAIL %s: strobe at cycle %0d vector %0d, expected no strobe", req, at, gv);
    end
  endtask

  task automatic collect(input int span);
    seen_n = 0; seen_c0 = -1;
    for (int c = 1; c <= span; c++) begin
      cyc();
      if (vld_o) begin
        if (seen_c0 < 0) seen_c0 = c;
        if (seen_n < 8) seen[seen_n] = vec_o;
        seen_n++;
      end
    end
  endtask

  task automatic wr_en(input logic [1:0] we, input logic [7:0] d);
    en_we = we; en_wdata = d;
    cyc();
    en_we = 2'b00;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (4) begin
      cyc();
      check(vld_o == 1'b0, "R1 strobe low in reset", int'(vld_o), 0);
    end
    rst = 1'b0;
    expect_strobe(POI_C + 1, POI_C + 4, 1'b1, 8'd32, "R8 power-on vector");
  endtask

  initial begin : wd
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = $urandom(32'd20240611);
    cyc();
    do_reset();

    // R3 R10 R4: single edges, short interval
    trig_n[0] = 1'b0;
    expect_strobe(LIM_S + 3, LIM_S + 6, 1'b1, exp_vec(0, 0), "R3 R10 pin0 fall");
    trig_n[0] = 1'b1;
    expect_strobe(LIM_S + 3, LIM_S + 6, 1'b1, exp_vec(0, 1), "R3 R4 pin0 rise");

    // R2: glitch one clock short of the interval
    trig_n[2] = 1'b0;
    repeat (LIM_S - 1) cyc();
    trig_n[2] = 1'b1;
    expect_strobe(0, 2 * LIM_S, 1'b0, 8'h00, "R2 boundary glitch");

    // R2: long interval
    deb_long = 1'b1;
    trig_n[1] = 1'b0;
    expect_strobe(LIM_L + 3, LIM_L + 6, 1'b1, exp_vec(1, 0), "R2 R10 long fall");
    trig_n[1] = 1'b1;
    repeat (LIM_S + 4) cyc();
    trig_n[1] = 1'b0;
    expect_strobe(0, LIM_L + 6, 1'b0, 8'h00, "R2 short pulse in long mode");
    trig_n[1] = 1'b1;
    expect_strobe(LIM_L + 3, LIM_L + 6, 1'b1, exp_vec(1, 1), "R2 long rise");
    deb_long = 1'b0;

    // R2: random glitches
    for (int k = 0; k < 16; k++) begin
      int p, g;
      p = int'($urandom % 4);
      g = 1 + int'($urandom % (LIM_S - 1));
      trig_n[p] = ~trig_n[p];
      repeat (g) cyc();
      trig_n[p] = ~trig_n[p];
      expect_strobe(0, LIM_S + 4, 1'b0, 8'h00, "R2 random glitch");
    end

    // R5: masking and ignored bits
    wr_en(2'b01, 8'hEE);
    trig_n[0] = 1'b0;
    expect_strobe(0, LIM_S + 6, 1'b0, 8'h00, "R5 pin0 fall masked");
    trig_n[0] = 1'b1;
    expect_strobe(0, LIM_S + 6, 1'b0, 8'h00, "R5 pin0 rise masked");
    trig_n[1] = 1'b0;
    expect_strobe(LIM_S + 3, LIM_S + 6, 1'b1, exp_vec(1, 0), "R5 pin1 fall enabled");
    trig_n[1] = 1'b1;
    expect_strobe(LIM_S + 3, LIM_S + 6, 1'b1, exp_vec(1, 1), "R5 pin1 rise enabled");
    wr_en(2'b10, 8'hCC);
    trig_n[2] = 1'b0;
    expect_strobe(0, LIM_S + 6, 1'b0, 8'h00, "R5 ignored bits give no enable");
    trig_n[2] = 1'b1;
    expect_strobe(0, LIM_S + 6, 1'b0, 8'h00, "R5 pin2 rise masked");
    wr_en(2'b10, 8'h33);
    trig_n[3] = 1'b0;
    expect_strobe(LIM_S + 3, LIM_S + 6, 1'b1, exp_vec(3, 0), "R4 pin3 fall");
    trig_n[3] = 1'b1;
    expect_strobe(LIM_S + 3, LIM_S + 6, 1'b1, exp_vec(3, 1), "R4 pin3 rise");

    // R5 R4: random enables and edges
    for (int k = 0; k < 12; k++) begin
      logic [7:0] lo, hi;
      int p;
      bit rise, en;
      lo = 8'($urandom); hi = 8'($urandom);
      wr_en(2'b01, lo);
      wr_en(2'b10, hi);
      p = int'($urandom % 4);
      rise = (trig_n[p] == 1'b0);
      en = exp_en(lo, hi, p, rise);
      trig_n[p] = ~trig_n[p];
      expect_strobe(LIM_S + 3, LIM_S + 6, en, exp_vec(p, rise), "R5 random enable");
    end

    // restore: all enabled, all pins high, drain
    wr_en(2'b11, 8'hFF);
    trig_n = 4'hF;
    collect(LIM_S + 12);

    // R6 R7 R9: four falls and a jump land on the same edge
    trig_n = 4'h0;
    repeat (LIM_S + 1) cyc();
    jmp_req = 1'b1; jmp_tgt = 8'hA7;
    cyc();
    jmp_req = 1'b0;
    collect(8);
    check(seen_n == 5, "R7 strobe count", seen_n, 5);
    check(seen_c0 == 1, "R7 first strobe cycle", seen_c0, 1);
    for (int i = 0; i < 4; i++)
      check(seen[i] == exp_vec(i, 0), "R6 falling order", int'(seen[i]), int'(exp_vec(i, 0)));
    check(seen[4] == 8'hA7, "R9 jump after edges", int'(seen[4]), 8'hA7);

    // R6: four rises together
    trig_n = 4'hF;
    collect(LIM_S + 8);
    check(seen_n == 4 && seen_c0 == LIM_S + 3, "R6 R7 rise burst timing", seen_c0, LIM_S + 3);
    for (int i = 0; i < 4; i++)
      check(seen[i] == exp_vec(i, 1), "R6 rising order", int'(seen[i]), int'(exp_vec(i, 1)));

    // R9: lone jump
    jmp_req = 1'b1; jmp_tgt = 8'h3C;
    cyc();
    jmp_req = 1'b0;
    expect_strobe(1, 4, 1'b1, 8'h3C, "R9 lone jump");

    // R1: reset restores enables
    wr_en(2'b11, 8'h00);
    do_reset();
    trig_n[3] = 1'b0;
    expect_strobe(LIM_S + 3, LIM_S + 6, 1'b1, exp_vec(3, 0), "R1 enable default after reset");
    trig_n[3] = 1'b1;
    expect_strobe(LIM_S + 3, LIM_S + 6, 1'b1, exp_vec(3, 1), "R1 rise enable default");

    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule